// File: doc/BRIEF.md
# Cascadable TDM Frame Serializer

This block drives one serial line that carries a 256-bit frame split into eight 32-bit slots. Each block contributes one stereo pair: the left sample fills slot 0 and the right sample fills slot 1. Each sample is sent most significant bit first and followed by eight zero bits. Whatever the block receives on its cascade input leaves on its serial output 64 bit periods later, which puts it into slots 2 to 7. Up to four blocks can be chained, each block's serial output feeding the next block's cascade input. The last block then emits eight channels, and the first block in the chain ends up in the highest pair of slots. The cascade input of the first block is tied low.

The block has a single clock, which is the bit clock. In master mode it generates the frame clock itself, free running with a period of 256 bit clocks and an active phase one slot long. In slave mode it follows an external frame clock, whose active phase may be as short as one bit period. A format input selects the framing. In left-justified framing the frame clock is high during slot 0 and data starts with the frame. In I2S framing the frame clock is low during slot 0 and every data bit comes one bit period after the frame edge. Mode and format inputs are static and are changed only while reset is held.

Top module: `tdm_cascade_ser`

## Requirements
- R1: In master mode the frame is exactly 256 bit periods long, and the frame clock is in its active phase for the first 32 bit periods of each frame. The first frame begins with the first bit period after reset is released.
- R2: The active phase of the frame clock is high when i2sMode is 0 and low when i2sMode is 1. Outside the active phase the frame clock sits at the opposite level.
- R3: Frame positions 0 to 23 carry the left sample, MSB (bit 23) at position 0 down to bit 0 at position 23. A position is the bit period counted from the frame start.
- R4: Frame positions 32 to 55 carry the right sample in the same MSB-first order.
- R5: Positions 24 to 31 and 56 to 63 are driven low.
- R6: With i2sMode at 1, the bit sent at frame position p is the bit that left-justified framing puts at position p-1 (mod 256). This holds for both local and forwarded data.
- R7: The serial output in positions 64 to 255 equals the cascade input exactly 64 bit periods earlier. The cascade input is sampled on the falling edge of the bit clock, and the serial output changes on the rising edge.
- R8: The left and right samples are taken at the rising edge that starts a frame. Changes on the sample inputs later in that frame do not alter the bits sent during it.
- R9: In slave mode, a frame starts at the first rising edge of the bit clock at which the frame clock input is seen in its active phase (the R2 levels) after having been inactive at the previous edge. A one-bit-period active phase is enough. Position 0 goes out in the bit period right after that edge.
- R10: In slave mode the frame clock output stays at its inactive level.
- R11: While reset is held, the serial output is 0 and the frame clock output is at its inactive level. The cascade path is cleared, so the first 64 forwarded bits after reset are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 256 per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1: generate the frame clock, 0: follow frmIn |
| i2sMode | input | 1 | 0: left-justified framing, 1: I2S framing |
| frmIn | input | 1 | Frame clock input used in slave mode |
| frmOut | output | 1 | Frame clock output in master mode |
| casIn | input | 1 | Serial stream from the previous block in the chain |
| leftIn | input | 24 | Local left sample, two's complement |
| rightIn | input | 24 | Local right sample, two's complement |
| sdOut | output | 1 | Serial TDM output |

## Verification
The bench sweeps every bit position of several frames under both framings, in master mode and in slave mode. It uses both single-period and slot-long frame pulses, and it starts the slave frame at an offset from reset. This catches a counter that only looks synchronized because it happened to wrap at the right point. The cascade stream is a pseudo-random bit pattern, so a delay of 63 or 65 periods, or sampling on the rising edge, moves the forwarded data by one period and the checks fail. The sample inputs are inverted in the middle of every frame: a design that reads them live instead of holding them corrupts the later bits of a slot. Under I2S framing, a missing one-bit shift pulls the LSB out of the slot.

// File: rtl/tdm_ser_pkg.sv
`timescale 1ns/1ps
package tdm_ser_pkg;
  // strobes from the sequencer to the datapath, valid for the coming edge
  typedef struct packed {
    logic capture;    // frame start: load the local sample pair
    logic useLocal;   // next bit comes from a local slot
    logic pickRight;  // local slot is the right channel
    logic padZero;    // next bit is in the zero-filled tail of a local slot
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_ser_casdly.sv
`timescale 1ns/1ps
module tdm_ser_casdly #(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic casIn,
  output logic tail
);
  localparam int REG_STAGES = DEPTH - 1;

  // falling-edge capture is the first stage of the delay
  logic casQ;
  logic [REG_STAGES-1:0] stg;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) casQ <= 1'b0;
    else        casQ <= casIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[REG_STAGES-2:0], casQ};
  end

  assign tail = stg[REG_STAGES-1];

  // R11
  cas_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tail);
endmodule

// File: rtl/tdm_ser_ctrl.sv
`timescale 1ns/1ps
module tdm_ser_ctrl
  import tdm_ser_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 24,
  localparam int FRAME_W = SLOT_W * SLOTS,
  localparam int POS_W   = $clog2(FRAME_W),
  localparam int SLOT_BW = $clog2(SLOT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               masterMode,
  input  logic               i2sMode,
  input  logic               frmIn,
  output logic               frmActive,
  output tdmStrobe_t         stb,
  output logic [SLOT_BW-1:0] bitSel
);
  localparam int SLOT_IW     = POS_W - SLOT_BW;
  localparam int LOCAL_SLOTS = 2;

  logic [POS_W-1:0]   cnt, nextPos, dataPos;
  logic [SLOT_IW-1:0] slotIdx;
  logic               actNow, actQ, start;

  assign actNow  = frmIn ^ i2sMode;
  assign start   = masterMode ? (cnt == '1) : (actNow && !actQ);
  assign nextPos = start ? '0 : POS_W'(cnt + 1'b1);
  // I2S framing trails the frame edge by one bit period
  assign dataPos = i2sMode ? POS_W'(nextPos - 1'b1) : nextPos;
  assign slotIdx = dataPos[POS_W-1:SLOT_BW];
  assign bitSel  = dataPos[SLOT_BW-1:0];

  always_comb begin
    stb.capture   = start;
    stb.useLocal  = slotIdx < SLOT_IW'(LOCAL_SLOTS);
    stb.pickRight = slotIdx[0];
    stb.padZero   = bitSel >= SLOT_BW'(SAMPLE_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '1;
      actQ      <= 1'b0;
      frmActive <= 1'b0;
    end else begin
      cnt       <= nextPos;
      actQ      <= actNow;
      frmActive <= masterMode && (nextPos < POS_W'(SLOT_W));
    end
  end

  // R1
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> cnt == POS_W'($past(cnt) + 1'b1));
  // R2
  frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frmActive) |-> cnt == '0);
  // R9
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!masterMode && start) |=> cnt == '0);
  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!masterMode && !$past(masterMode)) |-> !frmActive);
endmodule

// File: rtl/tdm_ser_datapath.sv
`timescale 1ns/1ps
module tdm_ser_datapath
  import tdm_ser_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int CAS_DLY  = 64,
  localparam int SLOT_BW = $clog2(SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tdmStrobe_t          stb,
  input  logic [SLOT_BW-1:0]  bitSel,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                casIn,
  output logic                sdOut
);
  logic [SAMPLE_W-1:0] leftHold, rightHold, curLeft, curRight, smp, shifted;
  logic                casTail, localBit, nextBit;

  tdm_ser_casdly #(.DEPTH(CAS_DLY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .casIn (casIn),
    .tail  (casTail)
  );

  // at the frame-start edge the fresh inputs bypass the hold registers
  assign curLeft  = stb.capture ? leftIn  : leftHold;
  assign curRight = stb.capture ? rightIn : rightHold;
  assign smp      = stb.pickRight ? curRight : curLeft;
  assign shifted  = smp << bitSel;
  assign localBit = !stb.padZero && shifted[SAMPLE_W-1];
  assign nextBit  = stb.useLocal ? localBit : casTail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leftHold  <= '0;
      rightHold <= '0;
      sdOut     <= 1'b0;
    end else begin
      if (stb.capture) begin
        leftHold  <= leftIn;
        rightHold <= rightIn;
      end
      sdOut <= nextBit;
    end
  end

  // R5
  pad_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.useLocal && stb.padZero) |=> !sdOut);
  // R8
  take_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.capture |=> (leftHold == $past(leftIn)) && (rightHold == $past(rightIn)));
  // R8
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.capture |=> $stable(leftHold) && $stable(rightHold));
endmodule

// File: rtl/tdm_cascade_ser.sv
`timescale 1ns/1ps
module tdm_cascade_ser
  import tdm_ser_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 24,
  localparam int SLOT_BW = $clog2(SLOT_W),
  localparam int CAS_DLY = 2 * SLOT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                masterMode,
  input  logic                i2sMode,
  input  logic                frmIn,
  output logic                frmOut,
  input  logic                casIn,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sdOut
);
  tdmStrobe_t         stb;
  logic [SLOT_BW-1:0] bitSel;
  logic               frmActive;

  tdm_ser_ctrl #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .masterMode (masterMode),
    .i2sMode    (i2sMode),
    .frmIn      (frmIn),
    .frmActive  (frmActive),
    .stb        (stb),
    .bitSel     (bitSel)
  );

  tdm_ser_datapath #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .CAS_DLY(CAS_DLY)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .bitSel  (bitSel),
    .leftIn  (leftIn),
    .rightIn (rightIn),
    .casIn   (casIn),
    .sdOut   (sdOut)
  );

  assign frmOut = frmActive ^ i2sMode;
endmodule

// File: tb/sim_tdm_cascade_ser.sv
`timescale 1ns/1ps
module sim_tdm_cascade_ser;
  localparam int SW = 24;
  localparam int FB = 256;
  localparam int SL = 32;
  localparam int CD = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          masterMode = 1'b1;
  logic          i2sMode = 1'b0;
  logic          frmIn = 1'b0;
  logic          casIn = 1'b0;
  logic [SW-1:0] leftIn = '0;
  logic [SW-1:0] rightIn = '0;
  logic          frmOut, sdOut;

  int checks = 0;
  int fails  = 0;
  bit casHist [0:1023];

  always #4 clk = ~clk;

  tdm_cascade_ser u0 (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode), .i2sMode(i2sMode),
    .frmIn(frmIn), .frmOut(frmOut), .casIn(casIn),
    .leftIn(leftIn), .rightIn(rightIn), .sdOut(sdOut)
  );

  function automatic logic [SW-1:0] lval(int f);
    return SW'(f * 32'h0002D4F1 + 32'h009A0C35);
  endfunction

  function automatic logic [SW-1:0] rval(int f);
    return SW'((f * 32'h000051E3) ^ 32'h006BC871);
  endfunction

  function automatic bit hbit(int k);
    return bit'(((k * 13) ^ (k >> 2) ^ (k >> 5)) & 1);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runCfg(bit m, bit i2, int w, int s);
    int nj, j, dp, b, f;
    logic e;
    logic [SW-1:0] smp;
    string tag;
    masterMode = m; i2sMode = i2; rst_n = 1'b0;
    frmIn = i2; casIn = 1'b0;
    leftIn = lval(0); rightIn = rval(0);
    repeat (3) @(posedge clk);
    #3;
    chk("R11 serial output in reset", sdOut, 1'b0);
    chk("R11 frame clock in reset", frmOut, i2);
    @(posedge clk);
    #1 rst_n = 1'b1;
    frmIn = ((s == 0 && w > 0) ? 1'b1 : 1'b0) ^ i2;
    for (int k = 0; k < s + 3 * FB; k++) begin
      @(posedge clk);
      #1;
      casIn = hbit(k);
      casHist[k] = casIn;
      nj = k + 1 - s;
      j  = k - s;
      if (nj >= 0 && nj % FB == 0) begin
        leftIn  = lval(nj / FB);
        rightIn = rval(nj / FB);
      end
      // R8: disturb the sample inputs mid-frame
      if (j >= 0 && j % FB == 5) begin
        leftIn  = ~leftIn;
        rightIn = ~rightIn;
      end
      frmIn = ((nj >= 0 && nj % FB < w) ? 1'b1 : 1'b0) ^ i2;
      #2;
      if (m) chk("R1 R2 master frame clock", frmOut, (((k % FB) < SL) ? 1'b1 : 1'b0) ^ i2);
      else   chk("R10 slave frame clock idle", frmOut, i2);
      if (j >= 0) begin
        dp = i2 ? (j + FB - 1) % FB : j % FB;
        if (dp < 2 * SL) begin
          f   = j / FB;
          b   = dp % SL;
          smp = (dp < SL) ? lval(f) : rval(f);
          e   = (b < SW) ? smp[SW - 1 - b] : 1'b0;
          tag = (b >= SW) ? "R5 pad" : ((dp < SL) ? "R3 left" : "R4 right");
          if (j % FB > 5) tag = {tag, " R8"};
        end else begin
          e   = (k >= CD) ? casHist[k - CD] : 1'b0;
          tag = (k >= CD) ? "R7 cascade" : "R7 R11 cleared cascade";
        end
        if (i2) tag = {tag, " R6"};
        if (!m) tag = {tag, " R9"};
        chk(tag, sdOut, e);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    runCfg(1'b1, 1'b0, 0, 0);
    runCfg(1'b1, 1'b1, 0, 0);
    runCfg(1'b0, 1'b0, 1, 100);
    runCfg(1'b0, 1'b1, 1, 100);
    runCfg(1'b0, 1'b0, 32, 37);
    runCfg(1'b0, 1'b1, 32, 211);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule